// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a small serial EEPROM that a host reaches over three wires: a chip select, a shift clock and a serial data input. The block answers on a serial data output, which comes with its own output-enable. A 2 Kbit array of on-chip registers holds the contents. A strap input picks how the host sees that array. With the strap low it is 256 bytes with a 9-bit address field. With the strap high it is 128 sixteen-bit words with an 8-bit address field.

The block samples the shift clock and chip select with the system clock. Every instruction starts with a 1 start bit, followed by a 2-bit opcode and an address field. The available operations are:
- single and streamed reads;
- writing or erasing one location;
- writing or erasing the whole array;
- enabling or disabling programming.

The "special" opcode is overloaded: the top two bits of its address field choose the operation. Every programming operation is followed by a self-timed busy period, counted in system clocks. If the host drops chip select and raises it again during that period, the block reports busy or ready on the data pin.

Top module: `ee3w_serial_eeprom`

## Requirements
- R1: An instruction is a start bit of 1, a 2-bit opcode sent MSB first, and an address field sent MSB first, all sampled on rising shift-clock edges while chip select is high. Zeros before the start bit are ignored. The address field is 9 bits with org_word=0 and 8 bits with org_word=1, and its top bit is a don't-care.
- R2: Opcode 10 is a read. On the rising edge that carries the last address bit, the output is enabled and drives a dummy 0. Each following rising edge shifts out one data bit, MSB first (8 bits in byte mode, 16 bits in word mode).
- R3: While chip select stays high, a read goes on to the next location without a dummy bit, and the address wraps from the last location to location 0.
- R4: After reset the array holds all ones and programming is disabled. While disabled, write, erase, write-all and erase-all change nothing and start no busy period. Reads work in either state.
- R5: Opcode 00 with top address bits 11 enables programming and with 00 disables it. The setting persists until changed.
- R6: Opcode 01 writes the 8 or 16 data bits that follow the address, MSB first. In word mode, word w occupies bytes 2w (high half) and 2w+1 (low half) of the byte view.
- R7: Opcode 11 sets every bit of the addressed location to 1.
- R8: Opcode 00 with top address bits 10 sets the whole array to ones. With top bits 01 it fills every location with the data that follows the address.
- R9: An accepted programming operation starts a busy period of PROG_CYCLES clocks. If chip select is lowered and raised during that period, the output is enabled and reads 0 while busy and 1 once ready. If chip select is raised after the period has ended, the output stays disabled.
- R10: The output is disabled whenever chip select is low.
- R11: If chip select falls before an instruction is complete, the instruction has no effect.
- R12: While a busy period runs, start bits are ignored and no new instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, sampled by clk |
| di | input | 1 | Serial data input |
| org_word | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data output, 0 when not enabled |
| dout_oe | output | 1 | Output enable for dout (tri-state control) |

## Verification
A vector table writes patterns to addresses at 0, at the top of the byte space, and with the don't-care address bit set. Reading them back shows whether the address field is cut at the right bit and whether data is shifted MSB first. Streamed reads across the end of the array, in both organizations, tell the no-dummy rollover apart from a restarted read. Reading the same bytes in both organizations checks the word-to-byte mapping. Writes issued while disabled, while busy, or cut short by chip select separate a correctly ignored instruction from one that leaks into the array. Status polling with a late chip select separates a real busy report from a stale ready bit.

// File: rtl/ee3w_pkg.sv
// Shared types for the three-wire serial EEPROM slave.
// Assumes: opcode values are fixed by the serial protocol.
package ee3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a start bit
        ST_OPC,     // shifting in the two opcode bits
        ST_ADDR,    // shifting in the address field
        ST_DATA,    // shifting in write data
        ST_READ,    // streaming read data out
        ST_DONE,    // instruction finished, wait for deselect
        ST_STATUS   // presenting ready/busy on the output
    } ee_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SUB_DIS  = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/ee3w_edge.sv
// Detects rising edges of the serial clock and chip select in the
// system clock domain. Assumes: inputs are already synchronous to clk
// and the serial clock is well below clk/2.
module ee3w_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_rise
);
    logic sk_q;
    logic cs_q;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q;
    assign cs_rise = cs & ~cs_q;
endmodule

// File: rtl/ee3w_prog_timer.sv
// Self-timed programming interval: a down-counter loaded on start.
// Assumes: start is a single-cycle pulse, CYCLES >= 1.
module ee3w_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start)       cnt_q <= CW'(CYCLES);
        else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != 0);
endmodule

// File: rtl/ee3w_array.sv
// Register array of 2**ADDR_W bytes with a byte or word view.
// In word view, word w is byte 2w (high half) and byte 2w+1 (low half).
// Data is left-justified in 16 bits: byte view uses bits 15:8.
// Assumes: wr_ptr is even in word view; wr_all overrides the pointer.
module ee3w_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic [15:0]       rd_word,
    input  logic              wr_req,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic [15:0]       wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        logic [7:0] cell_q;
        logic       hit;
        logic [7:0] wval;

        // Select this byte and the half of the data word it takes.
        always_comb begin
            hit  = word_mode ? (wr_ptr[ADDR_W-1:1] == IDX[ADDR_W-1:1])
                             : (wr_ptr == IDX);
            wval = (word_mode && IDX[0]) ? wr_data[7:0] : wr_data[15:8];
        end

        // Byte storage, erased (all ones) at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                      cell_q <= 8'hFF;
            else if (wr_req && (wr_all || hit)) cell_q <= wval;
        end

        assign mem[g] = cell_q;
    end

    logic [ADDR_W-1:0] even_ptr;
    logic [ADDR_W-1:0] odd_ptr;

    // Read port: one byte or one aligned byte pair.
    always_comb begin
        even_ptr = {rd_ptr[ADDR_W-1:1], 1'b0};
        odd_ptr  = {rd_ptr[ADDR_W-1:1], 1'b1};
        rd_word  = word_mode ? {mem[even_ptr], mem[odd_ptr]}
                             : {mem[rd_ptr], 8'h00};
    end
endmodule

// File: rtl/ee3w_serial_eeprom.sv
// Three-wire serial EEPROM slave: instruction decoder, programming
// enable latch, streamed reads, single/bulk write and erase, and
// ready/busy reporting. Assumes: cs, sk and di are synchronous to clk,
// and sk stays high and low for at least two clk cycles each.
module ee3w_serial_eeprom #(
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org_word,
    output logic dout,
    output logic dout_oe
);
    import ee3w_pkg::*;

    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] LAST_F8  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_F16 = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_D8  = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_D16 = CNT_W'(15);

    logic              sk_rise;
    logic              cs_rise;
    logic              busy;
    logic [15:0]       rd_word;

    ee_state_e         state_q;
    logic [1:0]        op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W:0]   addr_sr;
    logic [15:0]       shift_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              dout_q;
    logic              prog_en_q;
    logic              wr_req_q;
    logic              wr_all_q;
    logic [15:0]       wr_data_q;

    logic [CNT_W-1:0]  field_last;
    logic [CNT_W-1:0]  data_last;
    logic [ADDR_W:0]   addr_nxt;
    logic [1:0]        sub_op;
    logic [ADDR_W-1:0] loc_ptr;
    logic [15:0]       data_nxt;
    logic [15:0]       data_al;
    logic [15:0]       rd_src;
    logic [ADDR_W-1:0] ptr_step;

    ee3w_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .cs      (cs),
        .sk_rise (sk_rise),
        .cs_rise (cs_rise)
    );

    ee3w_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_req_q),
        .busy  (busy)
    );

    ee3w_array #(.ADDR_W(ADDR_W)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_mode (org_word),
        .rd_ptr    (ptr_q),
        .rd_word   (rd_word),
        .wr_req    (wr_req_q),
        .wr_all    (wr_all_q),
        .wr_ptr    (ptr_q),
        .wr_data   (wr_data_q)
    );

    // Field lengths, decoded fields and the next read bit source.
    always_comb begin
        field_last = org_word ? LAST_F16 : LAST_F8;
        data_last  = org_word ? LAST_D16 : LAST_D8;
        addr_nxt   = {addr_sr[ADDR_W-1:0], di};
        sub_op     = org_word ? addr_nxt[ADDR_W-1 -: 2] : addr_nxt[ADDR_W -: 2];
        loc_ptr    = org_word ? {addr_nxt[ADDR_W-2:0], 1'b0} : addr_nxt[ADDR_W-1:0];
        data_nxt   = {shift_q[14:0], di};
        data_al    = org_word ? data_nxt : {data_nxt[7:0], 8'h00};
        rd_src     = (cnt_q == '0) ? rd_word : shift_q;
        ptr_step   = org_word ? ADDR_W'(2) : ADDR_W'(1);
    end

    // Instruction sequencer, advanced by rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            cnt_q     <= '0;
            addr_sr   <= '0;
            shift_q   <= '0;
            ptr_q     <= '0;
            dout_q    <= 1'b0;
            prog_en_q <= 1'b0;
            wr_req_q  <= 1'b0;
            wr_all_q  <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_req_q <= 1'b0;
            if (!cs) begin
                state_q <= ST_IDLE;
            end else if (cs_rise) begin
                state_q <= busy ? ST_STATUS : ST_IDLE;
            end else if (sk_rise) begin
                case (state_q)
                    ST_IDLE: begin
                        if (di && !busy) begin
                            state_q <= ST_OPC;
                            cnt_q   <= '0;
                        end
                    end
                    ST_OPC: begin
                        op_q <= {op_q[0], di};
                        if (cnt_q == CNT_W'(1)) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sr <= addr_nxt;
                        if (cnt_q == field_last) begin
                            cnt_q   <= '0;
                            ptr_q   <= loc_ptr;
                            state_q <= ST_DONE;
                            case (op_q)
                                OP_READ: begin
                                    state_q <= ST_READ;
                                    dout_q  <= 1'b0;
                                end
                                OP_WRITE: state_q <= ST_DATA;
                                OP_ERASE: begin
                                    if (prog_en_q) begin
                                        wr_req_q  <= 1'b1;
                                        wr_all_q  <= 1'b0;
                                        wr_data_q <= 16'hFFFF;
                                    end
                                end
                                default: begin
                                    case (sub_op)
                                        SUB_EN:  prog_en_q <= 1'b1;
                                        SUB_DIS: prog_en_q <= 1'b0;
                                        SUB_ERAL: begin
                                            if (prog_en_q) begin
                                                wr_req_q  <= 1'b1;
                                                wr_all_q  <= 1'b1;
                                                wr_data_q <= 16'hFFFF;
                                            end
                                        end
                                        default: state_q <= ST_DATA;
                                    endcase
                                end
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        shift_q <= data_nxt;
                        if (cnt_q == data_last) begin
                            state_q <= ST_DONE;
                            if (prog_en_q) begin
                                wr_req_q  <= 1'b1;
                                wr_all_q  <= (op_q == OP_SPECIAL);
                                wr_data_q <= data_al;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_READ: begin
                        dout_q  <= rd_src[15];
                        shift_q <= {rd_src[14:0], 1'b0};
                        if (cnt_q == data_last) begin
                            cnt_q <= '0;
                            ptr_q <= ptr_q + ptr_step;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output pin: read data or ready/busy, otherwise released.
    always_comb begin
        dout_oe = (state_q == ST_READ) || (state_q == ST_STATUS);
        if (state_q == ST_STATUS) dout = ~busy;
        else                      dout = (state_q == ST_READ) & dout_q;
    end
endmodule

// File: rtl/ee3w_checker.sv
// Protocol checker for the serial EEPROM slave, attached by bind.
// Assumes: signals are sampled on clk with rst_n active low.
module ee3w_checker (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic dout_oe,
    input logic busy,
    input logic prog_en,
    input logic wr_req,
    input logic sk_rise,
    input logic cs_rise,
    input logic in_idle,
    input logic in_status
);
    // R10: a deselected part releases the pin by the next cycle.
    p_hiz_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !dout_oe);

    // R4: no array update unless programming is enabled.
    p_write_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> prog_en);

    // R9: an accepted program operation starts the busy period.
    p_timer_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> busy);

    // R9: status shows the inverse of busy on an enabled pin.
    p_status_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_status |-> (dout_oe && (dout == !busy)));

    // R12: a start bit during the busy period is not accepted.
    p_no_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_idle && sk_rise && cs && !cs_rise) |=> in_idle);
endmodule

bind ee3w_serial_eeprom ee3w_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .busy      (busy),
    .prog_en   (prog_en_q),
    .wr_req    (wr_req_q),
    .sk_rise   (sk_rise),
    .cs_rise   (cs_rise),
    .in_idle   (state_q == ee3w_pkg::ST_IDLE),
    .in_status (state_q == ee3w_pkg::ST_STATUS)
);

// File: tb/test_ee3w_serial_eeprom.sv
module test_ee3w_serial_eeprom;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 300;

    // Vector table: {9-bit address field, byte data}, byte organization.
    localparam logic [16:0] VEC [0:5] = '{
        {9'h000, 8'h3C}, {9'h0FF, 8'hA5}, {9'h1AB, 8'h00},
        {9'h055, 8'hFF}, {9'h080, 8'h81}, {9'h101, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org_word = 1'b0;
    logic dout, dout_oe;
    logic last_dout, last_oe;
    logic [15:0] rd_buf [0:3];
    int checks = 0, failures = 0;

    ee3w_serial_eeprom #(.ADDR_W(8), .PROG_CYCLES(PROG)) i_ee3w_serial_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .org_word(org_word), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One serial bit; outputs are sampled late in the high phase.
    task automatic pulse(input logic b);
        @(negedge clk) di = b;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        repeat (2) @(negedge clk);
        last_dout = dout;
        last_oe   = dout_oe;
        sk = 1'b0;
    endtask

    task automatic select();
        @(negedge clk) cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic deselect();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        repeat (3) @(negedge clk);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [8:0] addr);
        int nb;
        nb = org_word ? 8 : 9;
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = nb - 1; i >= 0; i--) pulse(addr[i]);
    endtask

    task automatic send_data(input logic [15:0] data);
        int nb;
        nb = org_word ? 16 : 8;
        for (int i = nb - 1; i >= 0; i--) pulse(data[i]);
    endtask

    task automatic read_seq(input logic [8:0] addr, input int n, input string tag);
        logic [15:0] w;
        int nb;
        nb = org_word ? 16 : 8;
        select();
        send_head(2'b10, addr);
        check_eq({tag, " R2 dummy bit"}, {14'd0, last_oe, last_dout}, 16'h0002);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < nb; b++) begin
                pulse(1'b0);
                w = {w[14:0], last_dout};
            end
            rd_buf[k] = w;
        end
        deselect();
    endtask

    task automatic write_loc(input logic [8:0] addr, input logic [15:0] data);
        select();
        send_head(2'b01, addr);
        send_data(data);
        deselect();
    endtask

    task automatic special(input logic [1:0] sub, input logic [15:0] data);
        logic [8:0] a;
        a = org_word ? {1'b0, sub, 6'd0} : {sub, 7'd0};
        select();
        send_head(2'b00, a);
        if (sub == 2'b01) send_data(data);
        deselect();
    endtask

    task automatic wait_ready(output bit saw_busy);
        bit done;
        saw_busy = 0;
        done = 0;
        select();
        for (int i = 0; i < 2000 && !done; i++) begin
            @(negedge clk);
            if (dout_oe && !dout) saw_busy = 1;
            if (dout_oe && dout) done = 1;
        end
        deselect();
        check_eq("R9 ready reported", {15'd0, done}, 16'h0001);
    endtask

    task automatic check_no_status(input string tag);
        select();
        repeat (3) @(negedge clk);
        check_eq(tag, {15'd0, dout_oe}, 16'h0000);
        deselect();
    endtask

    initial begin
        bit sb;
        logic [15:0] w;

        repeat (5) @(negedge clk);
        check_eq("R10 output disabled in reset", {15'd0, dout_oe}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: reset contents readable while programming is disabled
        read_seq(9'h010, 1, "R4");
        check_eq("R4 reset contents all ones", rd_buf[0], 16'h00FF);

        // R4: write ignored while disabled, no busy period
        write_loc(9'h005, 16'h0012);
        check_no_status("R4 no busy after disabled write");
        read_seq(9'h005, 1, "R4");
        check_eq("R4 disabled write ignored", rd_buf[0], 16'h00FF);

        // R5: enable programming, then walk the vector table
        special(2'b11, 16'h0);
        for (int v = 0; v < 6; v++) begin
            write_loc(VEC[v][16:8], {8'h00, VEC[v][7:0]});
            wait_ready(sb);
            if (v == 0) check_eq("R9 busy seen after write", {15'd0, sb}, 16'h0001);
        end
        for (int v = 0; v < 6; v++) begin
            read_seq({1'b0, VEC[v][15:8]}, 1, "R6");
            check_eq("R6/R1 table write readback", rd_buf[0], {8'h00, VEC[v][7:0]});
        end

        // R1: leading zeros before the start bit
        select();
        pulse(1'b0);
        pulse(1'b0);
        send_head(2'b10, 9'h0FF);
        w = '0;
        for (int b = 0; b < 8; b++) begin pulse(1'b0); w = {w[14:0], last_dout}; end
        deselect();
        check_eq("R1 leading zeros ignored", w, 16'h00A5);

        // R3: stream across the top of the byte space
        read_seq(9'h0FF, 3, "R3");
        check_eq("R3 seq byte 0xFF", rd_buf[0], 16'h00A5);
        check_eq("R3 seq wrap byte 0x00", rd_buf[1], 16'h003C);
        check_eq("R3 seq byte 0x01", rd_buf[2], 16'h007E);

        // R9: status polling, and no status once the cycle is over
        write_loc(9'h020, 16'h005A);
        wait_ready(sb);
        check_eq("R9 busy then ready", {15'd0, sb}, 16'h0001);
        repeat (PROG + 20) @(negedge clk);
        check_no_status("R9 no status after cycle end");

        // R12: instruction issued during busy is ignored
        write_loc(9'h021, 16'h0011);
        select();
        send_head(2'b01, 9'h021);
        send_data(16'h0099);
        deselect();
        wait_ready(sb);
        read_seq(9'h021, 1, "R12");
        check_eq("R12 busy write ignored", rd_buf[0], 16'h0011);

        // R11: instruction cut short by chip select
        select();
        send_head(2'b01, 9'h021);
        for (int b = 0; b < 4; b++) pulse(1'b0);
        deselect();
        check_no_status("R11 aborted write starts nothing");
        read_seq(9'h021, 1, "R11");
        check_eq("R11 aborted write no change", rd_buf[0], 16'h0011);

        // R7: erase one location
        select();
        send_head(2'b11, 9'h020);
        deselect();
        wait_ready(sb);
        read_seq(9'h020, 1, "R7");
        check_eq("R7 erase to ones", rd_buf[0], 16'h00FF);

        // R6: word organization and its byte mapping
        org_word = 1'b1;
        write_loc(9'h003, 16'h1234);
        wait_ready(sb);
        write_loc(9'h004, 16'hBEEF);
        wait_ready(sb);
        read_seq(9'h003, 2, "R6");
        check_eq("R6 word write", rd_buf[0], 16'h1234);
        check_eq("R3 word seq next", rd_buf[1], 16'hBEEF);
        read_seq(9'h07F, 2, "R3");
        check_eq("R3 word 127", rd_buf[0], 16'hFFA5);
        check_eq("R3 word wrap to 0", rd_buf[1], 16'h3C7E);
        org_word = 1'b0;
        read_seq(9'h006, 2, "R6");
        check_eq("R6 word high byte at 2w", rd_buf[0], 16'h0012);
        check_eq("R6 word low byte at 2w+1", rd_buf[1], 16'h0034);

        // R8: write-all then erase-all in word organization
        org_word = 1'b1;
        special(2'b01, 16'hA55A);
        wait_ready(sb);
        read_seq(9'h000, 1, "R8");
        check_eq("R8 write-all word 0", rd_buf[0], 16'hA55A);
        read_seq(9'h07F, 1, "R8");
        check_eq("R8 write-all word 127", rd_buf[0], 16'hA55A);
        special(2'b10, 16'h0);
        wait_ready(sb);
        read_seq(9'h040, 1, "R8");
        check_eq("R8 erase-all", rd_buf[0], 16'hFFFF);

        // R5: disable, then a write is ignored
        special(2'b00, 16'h0);
        write_loc(9'h005, 16'h0000);
        check_no_status("R5 no busy when disabled");
        read_seq(9'h005, 1, "R5");
        check_eq("R5 write after disable ignored", rd_buf[0], 16'hFFFF);

        // R10: output released while deselected
        check_eq("R10 deselected output disabled", {15'd0, dout_oe}, 16'h0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule